// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block translates a 32-bit logical address into a physical page address by walking a three-level tree of descriptors held in memory. A request names the address and the kind of access: supervisor or user, code or data, load or store, and two qualifiers. A debug access leaves memory untouched. A probe access also returns a status word. The walker picks the supervisor or the user root pointer, reads a root descriptor, then a pointer descriptor, then a page descriptor. When the page descriptor is indirect, it reads one more word. Along the way it sets used and modified bits in memory.

Requests enter on a valid/ready stream. The walker accepts one request only when it is idle, so `req_ready` stays low from acceptance until the result has been taken. The result leaves on a second valid/ready stream. Once `rsp_valid` is raised, every result field holds steady until the cycle in which `rsp_ready` is high; that cycle is the completion pulse. Memory is reached through a single word port. A request there must be held unchanged until `mem_req_ready`. Writes are posted and finish at their handshake. Each read is answered by exactly one `mem_rsp_valid` pulse, which may come any number of cycles later. Only one memory access is outstanding at a time.

The table-base and page-size inputs are plain levels. The root pointers are sampled when a request is accepted, and the page size is captured with the request.

Top module: `pgwalk_engine`

## Requirements
- R1: The root pointer is `root_sup` when `req_super`=1 and `root_usr` otherwise. The first read goes to {root[31:9], vaddr[31:25], 2'b00}.
- R2: A root or pointer descriptor is valid when bit 1 is set. An invalid one ends the walk with a fault. The pointer-level read goes to {rootdesc[31:9], vaddr[24:18], 2'b00}.
- R3: A valid root or pointer descriptor whose used bit (bit 3) is clear is written back to the address it came from, with bit 3 set, before the walk continues. A debug access never writes memory.
- R4: Write-protect (bit 2) at the root or pointer level clears write permission. It makes a store fault at once, with no further reads. On a probe it sets status bit 2.
- R5: With `page_8k`=0 the page entry is at {ptrdesc[31:8], vaddr[17:12], 2'b00} and the physical page is desc[31:12]<<12. With `page_8k`=1 the entry is at {ptrdesc[31:7], vaddr[17:13], 2'b00} and the page is desc[31:13]<<13.
- R6: A page descriptor type field (bits 1:0) of 0 faults. A type of 2 is indirect: the real descriptor is read from {desc[31:2], 2'b00}. Types 1 and 3 are final.
- R7: At the page level, all write-backs go to the page-table entry address, and none happen on debug accesses. A load sets used. A store to a page without bit 2 sets used and modified (bit 4) unless both are already set. A store to a write-protected page sets only used and then faults.
- R8: On success, read permission is 1, write permission is 0 if any level had bit 2, and execute permission equals `req_code`. A page with bit 7 set faults a user access.
- R9: For a probe that reached the page-level checks, the status word is {page[31:12], desc[11:3], any-WP, 0, 1}. For a probe that faulted earlier, it holds only any-WP in bit 2. For non-probes it is zero.
- R10: On a fault, `rsp_paddr` and all permissions are 0 and `fault_addr` latches the logical address. The fault word is bit 10=1, bits 9:8 = size (byte 01, word 10, long 00, from `req_size` 0/1/2), bit 4 = not store, bit 2 = supervisor, bit 1 = code, bit 0 = data. On success the fault word is 0.
- R11: Memory requests stay stable while stalled, and the walker issues no new access until the previous read has been answered.
- R12: `req_ready` is high only while idle. A presented result holds all fields until `rsp_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request taken |
| req_vaddr | input | 32 | Logical address |
| req_super | input | 1 | Supervisor access |
| req_code | input | 1 | Instruction fetch |
| req_store | input | 1 | Store access |
| req_debug | input | 1 | Debug access, no memory writes |
| req_probe | input | 1 | Probe, build status word |
| req_size | input | 2 | Access size 0 byte, 1 word, 2 long |
| root_sup | input | 32 | Supervisor root table pointer |
| root_usr | input | 32 | User root table pointer |
| page_8k | input | 1 | 1 selects 8 KiB pages |
| mem_req_valid | output | 1 | Memory access request |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_we | output | 1 | 1 write, 0 read |
| mem_req_addr | output | 32 | Word address (byte units) |
| mem_req_wdata | output | 32 | Write-back descriptor |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_rdata | input | 32 | Read data |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Result consumer ready |
| rsp_fault | output | 1 | Walk faulted |
| rsp_paddr | output | 32 | Physical page address |
| rsp_perm_r | output | 1 | Read allowed |
| rsp_perm_w | output | 1 | Write allowed |
| rsp_perm_x | output | 1 | Execute allowed |
| rsp_probe_status | output | 32 | Probe status word |
| rsp_fault_status | output | 32 | Fault status word |
| fault_addr | output | 32 | Logical address of last fault |

## Verification
The bench aims at the ordering of writes against reads. A walker that checked write-protect before writing the used bit back would skip the write that must precede a store fault. One that wrote the page update to the indirect target instead of to the table entry would leave a different word changed in memory. Indirect descriptors, 8 KiB index selection and supervisor-only pages are driven on purpose. A wrong index width reads the neighbouring entry and returns the wrong page. Debug walks over descriptors with clear used bits would expose any stray write. Probe walks that fault at a table level expose a status word built from stale page fields. Random tables with memory stalls and held results cover the stream rules.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;
  localparam int DB_WP   = 2;
  localparam int DB_USED = 3;
  localparam int DB_MOD  = 4;
  localparam int DB_SUPV = 7;

  typedef enum logic [2:0] {
    S_IDLE, S_RD, S_WAIT, S_CHK, S_WB, S_APPLY, S_RESP
  } walk_st_e;

  typedef struct packed {
    logic       super_m;
    logic       code;
    logic       store;
    logic       debug;
    logic       probe;
    logic [1:0] size;
    logic       pg8k;
  } acc_t;
endpackage

// File: rtl/pgwalk_entry_addr.sv
module pgwalk_entry_addr #(
  parameter int VA_W       = 32,
  parameter int ROOT_IDX_W = 7,
  parameter int PTR_IDX_W  = 7
) (
  input  logic [1:0]      level,
  input  logic [VA_W-1:0] base,
  input  logic [VA_W-1:0] vaddr,
  input  logic            pg8k,
  output logic [VA_W-1:0] entry
);
  localparam int PG4_IDX_W = VA_W - ROOT_IDX_W - PTR_IDX_W - 12;
  localparam int PG8_IDX_W = PG4_IDX_W - 1;
  localparam int RT_LSB    = ROOT_IDX_W + 2;
  localparam int PT_LSB    = PTR_IDX_W + 2;
  localparam int P4_LSB    = PG4_IDX_W + 2;
  localparam int P8_LSB    = PG8_IDX_W + 2;

  logic unused_bits;
  assign unused_bits = ^{base[P8_LSB-1:0], vaddr[11:0]};

  always_comb begin
    case (level)
      2'd0: entry = {base[VA_W-1:RT_LSB], vaddr[VA_W-1 -: ROOT_IDX_W], 2'b00};
      2'd1: entry = {base[VA_W-1:PT_LSB], vaddr[VA_W-ROOT_IDX_W-1 -: PTR_IDX_W], 2'b00};
      default: begin
        if (pg8k) entry = {base[VA_W-1:P8_LSB], vaddr[13 +: PG8_IDX_W], 2'b00};
        else      entry = {base[VA_W-1:P4_LSB], vaddr[12 +: PG4_IDX_W], 2'b00};
      end
    endcase
  end
endmodule

// File: rtl/pgwalk_status.sv
module pgwalk_status #(
  parameter int VA_W = 32
) (
  input  logic            fault,
  input  logic            probe,
  input  logic            pg_done,
  input  logic            wp_any,
  input  logic            super_m,
  input  logic            code,
  input  logic            store,
  input  logic [1:0]      size,
  input  logic [VA_W-1:0] ppage,
  input  logic [11:0]     pdesc_low,
  output logic [VA_W-1:0] probe_word,
  output logic [VA_W-1:0] fault_word
);
  logic [1:0] size_code;
  logic       unused_bits;
  assign unused_bits = ^{ppage[11:0], pdesc_low[2:0]};

  always_comb begin
    case (size)
      2'd0:    size_code = 2'b01;
      2'd1:    size_code = 2'b10;
      default: size_code = 2'b00;
    endcase
  end

  always_comb begin
    if (!fault) fault_word = '0;
    else fault_word = VA_W'({1'b1, size_code, 3'b000, !store, 1'b0, super_m, code, !code});
  end

  always_comb begin
    if (!probe)       probe_word = '0;
    else if (pg_done) probe_word = {ppage[VA_W-1:12], pdesc_low[11:3], wp_any, 1'b0, 1'b1};
    else              probe_word = VA_W'({wp_any, 2'b00});
  end
endmodule

// File: rtl/pgwalk_engine.sv
module pgwalk_engine
  import pgwalk_pkg::*;
#(
  parameter int VA_W       = 32,
  parameter int ROOT_IDX_W = 7,
  parameter int PTR_IDX_W  = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [VA_W-1:0] req_vaddr,
  input  logic            req_super,
  input  logic            req_code,
  input  logic            req_store,
  input  logic            req_debug,
  input  logic            req_probe,
  input  logic [1:0]      req_size,
  input  logic [VA_W-1:0] root_sup,
  input  logic [VA_W-1:0] root_usr,
  input  logic            page_8k,
  output logic            mem_req_valid,
  input  logic            mem_req_ready,
  output logic            mem_req_we,
  output logic [VA_W-1:0] mem_req_addr,
  output logic [VA_W-1:0] mem_req_wdata,
  input  logic            mem_rsp_valid,
  input  logic [VA_W-1:0] mem_rsp_rdata,
  output logic            rsp_valid,
  input  logic            rsp_ready,
  output logic            rsp_fault,
  output logic [VA_W-1:0] rsp_paddr,
  output logic            rsp_perm_r,
  output logic            rsp_perm_w,
  output logic            rsp_perm_x,
  output logic [VA_W-1:0] rsp_probe_status,
  output logic [VA_W-1:0] rsp_fault_status,
  output logic [VA_W-1:0] fault_addr
);
  localparam int PG4_OFF = 12;
  localparam int PG8_OFF = 13;
  localparam logic [1:0] LVL_PAGE = 2'd2;

  walk_st_e        st_q;
  logic [1:0]      lvl_q;
  acc_t            acc_q;
  logic [VA_W-1:0] va_q, rd_addr_q, ent_q, d_q, paddr_q, fault_addr_q;
  logic            wp_q, ind_q, fault_q, pgfin_q;

  // entry address generator, shared by the accept and level-advance paths
  logic [1:0]      ag_lvl;
  logic [VA_W-1:0] ag_base, ag_va, ag_entry;
  logic            ag_p8;

  always_comb begin
    if (st_q == S_IDLE) begin
      ag_lvl  = 2'd0;
      ag_base = req_super ? root_sup : root_usr;
      ag_va   = req_vaddr;
      ag_p8   = page_8k;
    end else begin
      ag_lvl  = lvl_q + 2'd1;
      ag_base = d_q;
      ag_va   = va_q;
      ag_p8   = acc_q.pg8k;
    end
  end

  pgwalk_entry_addr #(.VA_W(VA_W), .ROOT_IDX_W(ROOT_IDX_W), .PTR_IDX_W(PTR_IDX_W)) addr_i (
    .level(ag_lvl), .base(ag_base), .vaddr(ag_va), .pg8k(ag_p8), .entry(ag_entry)
  );

  // descriptor decode
  logic tbl_lvl, d_wp, d_used, d_mod, d_supv, pg_st_wr, need_wb, pg_fault;
  logic [VA_W-1:0] wb_data, page_mask;

  assign tbl_lvl  = (lvl_q != LVL_PAGE);
  assign d_wp     = d_q[DB_WP];
  assign d_used   = d_q[DB_USED];
  assign d_mod    = d_q[DB_MOD];
  assign d_supv   = d_q[DB_SUPV];
  assign pg_st_wr = !tbl_lvl && acc_q.store && !d_wp;
  assign pg_fault = (d_wp && acc_q.store) || (d_supv && !acc_q.super_m);
  assign page_mask = acc_q.pg8k ? ({VA_W{1'b1}} << PG8_OFF) : ({VA_W{1'b1}} << PG4_OFF);

  always_comb begin
    if (acc_q.debug)   need_wb = 1'b0;
    else if (pg_st_wr) need_wb = !(d_used && d_mod);
    else               need_wb = !d_used;
  end

  always_comb begin
    wb_data = d_q;
    wb_data[DB_USED] = 1'b1;
    if (pg_st_wr) wb_data[DB_MOD] = 1'b1;
  end

  // walk sequencer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q         <= S_IDLE;
      lvl_q        <= 2'd0;
      acc_q        <= '0;
      va_q         <= '0;
      rd_addr_q    <= '0;
      ent_q        <= '0;
      d_q          <= '0;
      paddr_q      <= '0;
      fault_addr_q <= '0;
      wp_q         <= 1'b0;
      ind_q        <= 1'b0;
      fault_q      <= 1'b0;
      pgfin_q      <= 1'b0;
    end else begin
      case (st_q)
        S_IDLE: if (req_valid) begin
          acc_q     <= '{super_m: req_super, code: req_code, store: req_store,
                         debug: req_debug, probe: req_probe, size: req_size, pg8k: page_8k};
          va_q      <= req_vaddr;
          lvl_q     <= 2'd0;
          rd_addr_q <= ag_entry;
          ent_q     <= ag_entry;
          wp_q      <= 1'b0;
          ind_q     <= 1'b0;
          fault_q   <= 1'b0;
          pgfin_q   <= 1'b0;
          paddr_q   <= '0;
          st_q      <= S_RD;
        end
        S_RD: if (mem_req_ready) st_q <= S_WAIT;
        S_WAIT: if (mem_rsp_valid) begin
          d_q  <= mem_rsp_rdata;
          st_q <= S_CHK;
        end
        S_CHK: begin
          if ((tbl_lvl && !d_q[1]) || (!tbl_lvl && !ind_q && d_q[1:0] == 2'b00)) begin
            fault_q      <= 1'b1;
            fault_addr_q <= va_q;
            st_q         <= S_RESP;
          end else if (!tbl_lvl && !ind_q && d_q[1:0] == 2'b10) begin
            ind_q     <= 1'b1;
            rd_addr_q <= {d_q[VA_W-1:2], 2'b00};
            st_q      <= S_RD;
          end else if (need_wb) begin
            st_q <= S_WB;
          end else begin
            st_q <= S_APPLY;
          end
        end
        S_WB: if (mem_req_ready) st_q <= S_APPLY;
        S_APPLY: begin
          if (d_wp) wp_q <= 1'b1;
          if (tbl_lvl) begin
            if (d_wp && acc_q.store) begin
              fault_q      <= 1'b1;
              fault_addr_q <= va_q;
              st_q         <= S_RESP;
            end else begin
              lvl_q     <= lvl_q + 2'd1;
              rd_addr_q <= ag_entry;
              ent_q     <= ag_entry;
              st_q      <= S_RD;
            end
          end else begin
            pgfin_q <= 1'b1;
            paddr_q <= d_q & page_mask;
            fault_q <= pg_fault;
            if (pg_fault) fault_addr_q <= va_q;
            st_q    <= S_RESP;
          end
        end
        S_RESP: if (rsp_ready) st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  pgwalk_status #(.VA_W(VA_W)) status_i (
    .fault(fault_q), .probe(acc_q.probe), .pg_done(pgfin_q), .wp_any(wp_q),
    .super_m(acc_q.super_m), .code(acc_q.code), .store(acc_q.store), .size(acc_q.size),
    .ppage(paddr_q), .pdesc_low(d_q[11:0]),
    .probe_word(rsp_probe_status), .fault_word(rsp_fault_status)
  );

  assign req_ready     = (st_q == S_IDLE);
  assign mem_req_valid = (st_q == S_RD) || (st_q == S_WB);
  assign mem_req_we    = (st_q == S_WB);
  assign mem_req_addr  = (st_q == S_WB) ? ent_q : rd_addr_q;
  assign mem_req_wdata = wb_data;
  assign rsp_valid     = (st_q == S_RESP);
  assign rsp_fault     = fault_q;
  assign rsp_paddr     = fault_q ? '0 : paddr_q;
  assign rsp_perm_r    = !fault_q;
  assign rsp_perm_w    = !fault_q && !wp_q;
  assign rsp_perm_x    = !fault_q && acc_q.code;
  assign fault_addr    = fault_addr_q;

  // R11: a stalled memory request keeps its command and address
  p_mem_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we));

  // R3 / R7: debug walks never write memory
  p_dbg_nowrite_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_we |-> !acc_q.debug);

  // R7: every write-back carries the used bit
  p_wb_used_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_we |-> mem_req_wdata[DB_USED]);

  // R12: result fields hold while back-pressured
  p_rsp_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault)
      && $stable(rsp_probe_status) && $stable(rsp_fault_status));

  // R12: no new request accepted while a result waits
  p_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  // R10: a successful result carries an empty fault word
  p_fsw_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_fault |-> rsp_fault_status == '0);
endmodule

// File: tb/pgwalk_engine_tb_top.sv
module pgwalk_engine_tb_top;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, req_valid, req_ready, req_super, req_code, req_store, req_debug, req_probe;
  logic [1:0] req_size;
  logic [31:0] req_vaddr, root_sup, root_usr;
  logic page_8k;
  logic mem_req_valid, mem_req_ready, mem_req_we, mem_rsp_valid;
  logic [31:0] mem_req_addr, mem_req_wdata, mem_rsp_rdata;
  logic rsp_valid, rsp_ready, rsp_fault, rsp_perm_r, rsp_perm_w, rsp_perm_x;
  logic [31:0] rsp_paddr, rsp_probe_status, rsp_fault_status, fault_addr;

  pgwalk_engine dut_i (.*);

  localparam int MW = 2048;
  logic [31:0] mem [MW];
  logic [31:0] smem [MW];
  int n_chk = 0, n_fail = 0;
  int req_cnt = 0, srv_cnt = 0;
  logic [31:0] pend_a = '0;
  logic [31:0] wa [8];
  logic [31:0] wd [8];
  int wn = 0;
  logic [31:0] ew_a [8];
  logic [31:0] ew_d [8];
  int ewn;
  logic e_fault, e_r, e_w, e_x;
  logic [31:0] e_paddr, e_ps, e_fs, e_fa;

  always @(posedge clk) begin
    if (rst_n && mem_req_valid && mem_req_ready) begin
      if (mem_req_we) begin
        mem[mem_req_addr[12:2]] = mem_req_wdata;
        if (wn < 8) begin wa[wn] = mem_req_addr; wd[wn] = mem_req_wdata; end
        wn++;
      end else begin
        pend_a = mem_req_addr;
        req_cnt++;
      end
    end
  end

  always @(negedge clk) begin
    mem_req_ready = ($urandom % 4) != 0;
    if (req_cnt != srv_cnt && ($urandom % 3) != 0) begin
      mem_rsp_valid = 1'b1;
      mem_rsp_rdata = mem[pend_a[12:2]];
      srv_cnt++;
    end else begin
      mem_rsp_valid = 1'b0;
      mem_rsp_rdata = $urandom;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic put(input logic [31:0] a, input logic [31:0] v);
    mem[a[12:2]] = v;
    smem[a[12:2]] = v;
  endtask

  task automatic mwr(input logic [31:0] a, input logic [31:0] v);
    smem[a[12:2]] = v;
    if (ewn < 8) begin ew_a[ewn] = a; ew_d[ewn] = v; end
    ewn++;
  endtask

  // reference walk computed from the requirements on the shadow memory
  task automatic model(input logic [31:0] va, input bit sp, input bit cd, input bit st,
                       input bit dbg, input bit prb, input logic [1:0] sz, input bit p8);
    logic [31:0] root, ent, d, phys;
    logic [1:0] szc;
    bit wp = 0, flt = 0, fin = 0;
    ewn = 0;
    phys = '0;
    d = '0;
    root = sp ? root_sup : root_usr;                    // R1
    ent = {root[31:9], va[31:25], 2'b00};
    for (int l = 0; l < 2; l++) begin
      if (!flt) begin
        d = smem[ent[12:2]];
        if (!d[1]) flt = 1;                             // R2
        else begin
          if (!d[3] && !dbg) mwr(ent, d | 32'h8);       // R3
          if (d[2]) begin wp = 1; if (st) flt = 1; end  // R4
          if (!flt) begin
            if (l == 0) ent = {d[31:9], va[24:18], 2'b00};
            else if (p8) ent = {d[31:7], va[17:13], 2'b00};  // R5
            else ent = {d[31:8], va[17:12], 2'b00};
          end
        end
      end
    end
    if (!flt) begin
      d = smem[ent[12:2]];
      if (d[1:0] == 2'b00) flt = 1;                     // R6
      else begin
        if (d[1:0] == 2'b10) d = smem[d[12:2]];
        if (!dbg) begin                                 // R7
          if (st && !d[2]) begin
            if (d[4:3] != 2'b11) mwr(ent, d | 32'h18);
          end else if (!d[3]) mwr(ent, d | 32'h8);
        end
        phys = p8 ? {d[31:13], 13'b0} : {d[31:12], 12'b0};
        if (d[2]) wp = 1;
        fin = 1;
        if ((d[2] && st) || (d[7] && !sp)) flt = 1;     // R8
      end
    end
    szc = (sz == 2'd0) ? 2'b01 : (sz == 2'd1) ? 2'b10 : 2'b00;
    e_fault = flt;
    e_paddr = flt ? 32'h0 : phys;
    e_r = !flt;
    e_w = !flt && !wp;
    e_x = !flt && cd;
    if (!prb) e_ps = '0;
    else if (fin) e_ps = {phys[31:12], d[11:3], wp, 1'b0, 1'b1};
    else e_ps = {29'b0, wp, 2'b00};
    e_fs = flt ? {21'b0, 1'b1, szc, 3'b000, !st, 1'b0, sp, cd, !cd} : 32'h0;
    if (flt) e_fa = va;
  endtask

  task automatic walk(input logic [31:0] va, input bit sp, input bit cd, input bit st,
                      input bit dbg, input bit prb, input logic [1:0] sz, input bit p8,
                      input int hold, input string tag);
    logic [31:0] pa0, ps0;
    int g;
    model(va, sp, cd, st, dbg, prb, sz, p8);
    wn = 0;
    @(negedge clk);
    req_vaddr = va; req_super = sp; req_code = cd; req_store = st;
    req_debug = dbg; req_probe = prb; req_size = sz; page_8k = p8; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R12", {tag, " ready while busy"}, 32'(req_ready), 32'h0);
    g = 0;
    while (!rsp_valid && g < 2000) begin @(negedge clk); g++; end
    chk(rsp_valid == 1'b1, "R11", {tag, " result arrives"}, 32'(rsp_valid), 32'h1);
    pa0 = rsp_paddr; ps0 = rsp_probe_status;
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      chk(rsp_valid && rsp_paddr == pa0 && rsp_probe_status == ps0, "R12",
          {tag, " result held"}, rsp_paddr, pa0);
    end
    chk(rsp_fault == e_fault, "R10", {tag, " fault flag"}, 32'(rsp_fault), 32'(e_fault));
    chk(rsp_paddr == e_paddr, "R5", {tag, " physical page"}, rsp_paddr, e_paddr);
    chk({rsp_perm_r, rsp_perm_w, rsp_perm_x} == {e_r, e_w, e_x}, "R8", {tag, " permissions"},
        32'({rsp_perm_r, rsp_perm_w, rsp_perm_x}), 32'({e_r, e_w, e_x}));
    chk(rsp_probe_status == e_ps, "R9", {tag, " probe status"}, rsp_probe_status, e_ps);
    chk(rsp_fault_status == e_fs, "R10", {tag, " fault status"}, rsp_fault_status, e_fs);
    chk(fault_addr == e_fa, "R10", {tag, " fault address"}, fault_addr, e_fa);
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk(wn == ewn, "R7", {tag, " write-back count"}, 32'(wn), 32'(ewn));
    for (int i = 0; i < 8; i++)
      if (i < wn && i < ewn)
        chk(wa[i] == ew_a[i] && wd[i] == ew_d[i], "R3", {tag, " write-back word"}, wd[i], ew_d[i]);
  endtask

  initial begin
    #(8 * 190000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0; req_valid = 1'b0; rsp_ready = 1'b0;
    req_vaddr = '0; req_super = 0; req_code = 0; req_store = 0; req_debug = 0; req_probe = 0;
    req_size = '0; page_8k = 0; root_sup = 32'h0; root_usr = 32'h200;
    mem_req_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_rdata = '0;
    e_fa = '0;
    for (int i = 0; i < MW; i++) begin mem[i] = '0; smem[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R12", "reset ready", 32'(req_ready), 32'h1);
    chk(rsp_valid == 1'b0 && mem_req_valid == 1'b0, "R11", "reset idle",
        32'({rsp_valid, mem_req_valid}), 32'h0);
    chk(fault_addr == 32'h0, "R10", "reset fault address", fault_addr, 32'h0);

    // directed tables
    put(32'h204, 32'h0000_0402);
    put(32'h400, 32'h0000_0602);
    put(32'h60C, 32'h0000_1001);
    walk(32'h0200_3000, 0, 0, 0, 0, 0, 2'd2, 0, 2, "R1 R2 user load 4K");
    walk(32'h0200_3000, 0, 0, 1, 0, 0, 2'd2, 0, 0, "R7 store sets modified");
    put(32'h604, 32'h0000_2005);
    walk(32'h0200_3000, 0, 0, 1, 0, 1, 2'd1, 1, 1, "R5 R7 8K store to protected page");
    put(32'h614, 32'h0000_0702);
    put(32'h700, 32'h0000_3081);
    walk(32'h0200_5000, 0, 0, 0, 0, 0, 2'd2, 0, 0, "R6 R8 indirect supervisor-only");
    put(32'h004, 32'h0000_0402);
    walk(32'h0200_5000, 1, 1, 0, 0, 1, 2'd2, 0, 0, "R1 R9 supervisor probe fetch");
    put(32'h208, 32'h0000_040E);
    put(32'h600, 32'h0000_5009);
    walk(32'h0400_0000, 0, 0, 0, 0, 1, 2'd2, 0, 0, "R4 table write-protect load");
    walk(32'h0400_0000, 0, 0, 1, 0, 1, 2'd1, 0, 0, "R4 table write-protect store");
    put(32'h20C, 32'h0000_0402);
    put(32'h608, 32'h0000_6001);
    walk(32'h0600_2000, 0, 0, 1, 1, 0, 2'd2, 0, 0, "R3 debug store no write");
    walk(32'h0800_0000, 0, 1, 0, 0, 0, 2'd0, 0, 1, "R2 R10 invalid root");

    // random tables
    for (int i = 0; i < MW; i++) begin
      logic [31:0] r;
      r = $urandom & 32'h0000_1FFF;
      mem[i] = r; smem[i] = r;
    end
    for (int n = 0; n < 80; n++) begin
      walk($urandom, 1'($urandom), 1'($urandom), 1'($urandom), (($urandom % 5) == 0),
           1'($urandom), 2'($urandom), 1'($urandom), int'($urandom % 3), "random walk");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule